// File: doc/BRIEF.md
# Internal Data Operand Address Resolver

This block maps an operand specifier of an 8-bit microcontroller onto a physical target in the on-chip data space. The inputs are a two-bit access kind, an eight-bit operand field, the two bank-select bits from the status word, and the byte held in the pointer register for pointer-based access. The outputs are a byte address, a flag that says whether that address lands in the special-function-register space or in internal RAM, a bit index, a bit-access flag, and an error flag for a pointer register that cannot be used.

The same byte window 80H-FFH reaches the special-function registers when the field names the address directly, and reaches upper RAM when the address comes from a pointer. An eight-bit bit address folds onto one of two byte regions. The lower half selects a bit inside the sixteen RAM bytes from 20H. The upper half selects a bit inside the special-function register at an eight-aligned address. A parameter selects a registered output with one clock of latency or a purely combinational one.

Top module: `oar_resolver`

## Requirements
- R1: Access kind code 2'b00 selects a working register. The byte address is bank*8 + field[2:0], where bank = {bank_i[1], bank_i[0]}. The space flag is 0 (RAM).
- R2: In register access, field[7:3] has no effect. The four banks occupy 00H-07H, 08H-0FH, 10H-17H and 18H-1FH.
- R3: Access kind code 2'b01 selects a direct address. The byte address equals the field. The space flag is 1 exactly when the field is 80H or above.
- R4: Access kind code 2'b10 with field[2:0] equal to 0 or 1 selects pointer access. The byte address equals ptr_i and the space flag is 0 for every pointer value, including 80H-FFH.
- R5: Pointer access with field[2:0] from 2 to 7 raises err_o. The byte address is 00H, and the space flag and the bit flag are 0.
- R6: Access kind code 2'b11 with a bit address below 80H gives byte address 20H + (field >> 3), space flag 0, bit index field[2:0] and bit flag 1.
- R7: Bit access with a bit address of 80H or above gives byte address field & F8H, space flag 1, bit index field[2:0] and bit flag 1.
- R8: Outside bit access the bit flag and the bit index are 0. err_o is 0 in every case except the one named in R5.
- R9: With the registered variant, the outputs reflect the inputs present at the previous rising clock edge. While reset is asserted, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| kind_i | input | 2 | Access kind: 00 register, 01 direct, 10 pointer, 11 bit |
| field_i | input | 8 | Operand field (register number, direct address, pointer register number or bit address) |
| bank_i | input | 2 | Bank-select bits, bit 1 is the high bank bit |
| ptr_i | input | 8 | Byte held in the selected pointer register |
| addr_o | output | 8 | Resolved byte address |
| sfr_o | output | 1 | 1: special-function-register space, 0: internal RAM |
| bidx_o | output | 3 | Bit position within the byte |
| bmode_o | output | 1 | Bit access in effect |
| err_o | output | 1 | Pointer access named an unusable register |

## Verification
The bench builds the block with its default parameters: eight-bit addresses, two bank bits, three index bits, bit-RAM base 20H and the registered output. The registered output puts the one-clock latency and the reset-clear behaviour within reach. The eight-bit width lets the bench cover the whole operand space: every bank with every register number, every bit address on both sides of 80H, and the upper window reached both directly and through a pointer. All six illegal pointer register numbers are also covered.

// File: rtl/oar_pkg.sv
package oar_pkg;
    parameter int ADDR_W = 8;
    parameter int BANK_W = 2;
    parameter int IDX_W  = 3;

    typedef enum logic [1:0] {
        KIND_REG = 2'b00,
        KIND_DIR = 2'b01,
        KIND_PTR = 2'b10,
        KIND_BIT = 2'b11
    } oar_kind_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              sfr;
        logic [IDX_W-1:0]  bidx;
        logic              bmode;
        logic              err;
    } oar_res_t;
endpackage

// File: rtl/oar_bank_map.sv
module oar_bank_map #(
    parameter int ADDR_W = 8,
    parameter int BANK_W = 2,
    parameter int IDX_W  = 3
) (
    input  logic [BANK_W-1:0] bank,
    input  logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] addr
);
    localparam int PAD_W = ADDR_W - BANK_W - IDX_W;

    // bank selects an 8-byte window, idx the byte within it
    assign addr = {{PAD_W{1'b0}}, bank, idx};
endmodule

// File: rtl/oar_bit_map.sv
module oar_bit_map #(
    parameter int              ADDR_W   = 8,
    parameter int              IDX_W    = 3,
    parameter logic [ADDR_W-1:0] RAM_BASE = 8'h20
) (
    input  logic [ADDR_W-1:0] bit_addr,
    output logic [ADDR_W-1:0] byte_addr,
    output logic              in_sfr,
    output logic [IDX_W-1:0]  bidx
);
    localparam int TOP = ADDR_W - 1;

    logic [ADDR_W-1:0] ram_byte;
    logic [ADDR_W-1:0] sfr_byte;

    assign ram_byte  = RAM_BASE + ADDR_W'(bit_addr[TOP-1:IDX_W]);
    assign sfr_byte  = {bit_addr[TOP:IDX_W], {IDX_W{1'b0}}};
    assign in_sfr    = bit_addr[TOP];
    assign byte_addr = in_sfr ? sfr_byte : ram_byte;
    assign bidx      = bit_addr[IDX_W-1:0];
endmodule

// File: rtl/oar_ptr_check.sv
module oar_ptr_check #(
    parameter int IDX_W   = 3,
    parameter int NUM_PTR = 2
) (
    input  logic [IDX_W-1:0] reg_num,
    output logic             usable
);
    assign usable = (int'(reg_num) < NUM_PTR);
endmodule

// File: rtl/oar_resolver.sv
module oar_resolver
    import oar_pkg::*;
#(
    parameter logic [ADDR_W-1:0] RAM_BASE = 8'h20,
    parameter bit                REG_OUT  = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        kind_i,
    input  logic [ADDR_W-1:0] field_i,
    input  logic [BANK_W-1:0] bank_i,
    input  logic [ADDR_W-1:0] ptr_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              sfr_o,
    output logic [IDX_W-1:0]  bidx_o,
    output logic              bmode_o,
    output logic              err_o
);
    logic [ADDR_W-1:0] reg_addr;
    logic [ADDR_W-1:0] bit_byte;
    logic              bit_sfr;
    logic [IDX_W-1:0]  bit_idx;
    logic              ptr_ok;
    oar_res_t          res_d;
    oar_res_t          res_q;

    oar_bank_map #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .IDX_W(IDX_W)) u_bank (
        .bank (bank_i),
        .idx  (field_i[IDX_W-1:0]),
        .addr (reg_addr)
    );

    oar_bit_map #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .RAM_BASE(RAM_BASE)) u_bit (
        .bit_addr  (field_i),
        .byte_addr (bit_byte),
        .in_sfr    (bit_sfr),
        .bidx      (bit_idx)
    );

    oar_ptr_check #(.IDX_W(IDX_W), .NUM_PTR(2)) u_ptr (
        .reg_num (field_i[IDX_W-1:0]),
        .usable  (ptr_ok)
    );

    always_comb begin
        res_d = '0;
        unique case (oar_kind_e'(kind_i))
            KIND_REG: res_d.addr = reg_addr;
            KIND_DIR: begin
                res_d.addr = field_i;
                res_d.sfr  = field_i[ADDR_W-1];
            end
            KIND_PTR: begin
                if (ptr_ok) res_d.addr = ptr_i;
                else        res_d.err  = 1'b1;
            end
            KIND_BIT: begin
                res_d.addr  = bit_byte;
                res_d.sfr   = bit_sfr;
                res_d.bidx  = bit_idx;
                res_d.bmode = 1'b1;
            end
            default: res_d = '0;
        endcase
    end

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) res_q <= '0;
                else        res_q <= res_d;
            end
        end else begin : g_comb
            assign res_q = res_d;
        end
    endgenerate

    assign addr_o  = res_q.addr;
    assign sfr_o   = res_q.sfr;
    assign bidx_o  = res_q.bidx;
    assign bmode_o = res_q.bmode;
    assign err_o   = res_q.err;
endmodule

// File: rtl/oar_chk.sv
module oar_chk
    import oar_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        kind_i,
    input logic [ADDR_W-1:0] field_i,
    input logic [BANK_W-1:0] bank_i,
    input logic [ADDR_W-1:0] ptr_i,
    input logic [ADDR_W-1:0] addr_o,
    input logic              sfr_o,
    input logic [IDX_W-1:0]  bidx_o,
    input logic              bmode_o,
    input logic              err_o
);
    logic primed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) primed_q <= 1'b0;
        else        primed_q <= 1'b1;
    end

    generate
        if (REG_OUT) begin : g_seq
            // R9: reset clears the outputs
            a_r9_reset_clear: assert property (@(posedge clk)
                !rst_n |-> (addr_o == '0 && !sfr_o && !bmode_o && !err_o));

            // R1: register access stays in the lower 32 RAM bytes
            a_r1_reg_window: assert property (@(posedge clk) disable iff (!rst_n || !primed_q)
                $past(kind_i) == 2'b00 |-> (addr_o[7:5] == 3'b000 && !sfr_o
                    && addr_o[4:3] == $past(bank_i)));

            // R3: direct access keeps the address and flags the upper half
            a_r3_direct_space: assert property (@(posedge clk) disable iff (!rst_n || !primed_q)
                $past(kind_i) == 2'b01 |-> (addr_o == $past(field_i)
                    && sfr_o == $past(field_i[7])));

            // R4: pointer access never reaches the register space
            a_r4_ptr_ram: assert property (@(posedge clk) disable iff (!rst_n || !primed_q)
                $past(kind_i) == 2'b10 |-> !sfr_o);

            // R6: lower bit addresses land in the bit-addressable RAM bytes
            a_r6_bit_ram: assert property (@(posedge clk) disable iff (!rst_n || !primed_q)
                ($past(kind_i) == 2'b11 && !$past(field_i[7])) |->
                    (addr_o[7:4] == 4'h2 && !sfr_o));

            // R7: upper bit addresses land on eight-aligned registers
            a_r7_bit_sfr: assert property (@(posedge clk) disable iff (!rst_n || !primed_q)
                ($past(kind_i) == 2'b11 && $past(field_i[7])) |->
                    (addr_o[2:0] == 3'b000 && sfr_o));

            // R8: bit flag only follows bit access
            a_r8_bmode: assert property (@(posedge clk) disable iff (!rst_n || !primed_q)
                bmode_o == ($past(kind_i) == 2'b11));

            // R5: the error flag only follows pointer access
            a_r5_err_kind: assert property (@(posedge clk) disable iff (!rst_n || !primed_q)
                err_o |-> ($past(kind_i) == 2'b10 && addr_o == '0 && !bmode_o));

            // R8: error and bit flag never together
            a_r8_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
                $countones({err_o, bmode_o}) <= 1);
        end else begin : g_cmb
            always_comb begin
                if (rst_n && kind_i == 2'b10) begin
                    a_r4_ptr_ram_c: assert (!sfr_o);
                end
                if (rst_n && kind_i == 2'b01) begin
                    a_r3_direct_space_c: assert (sfr_o == field_i[7]);
                end
            end
        end
    endgenerate

    logic unused_ok;
    assign unused_ok = ^{ptr_i, bidx_o};
endmodule

bind oar_resolver oar_chk #(.REG_OUT(REG_OUT)) u_chk (.*);

// File: tb/tb_oar_resolver.sv
module tb_oar_resolver;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] kind_i = '0;
    logic [7:0] field_i = '0;
    logic [1:0] bank_i = '0;
    logic [7:0] ptr_i = '0;
    logic [7:0] addr_o;
    logic       sfr_o;
    logic [2:0] bidx_o;
    logic       bmode_o;
    logic       err_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [13:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;  // 250 MHz

    oar_resolver dut (
        .clk(clk), .rst_n(rst_n), .kind_i(kind_i), .field_i(field_i),
        .bank_i(bank_i), .ptr_i(ptr_i), .addr_o(addr_o), .sfr_o(sfr_o),
        .bidx_o(bidx_o), .bmode_o(bmode_o), .err_o(err_o)
    );

    // expected {addr, sfr, bidx, bmode, err} from the requirements
    function automatic logic [13:0] model(input logic [1:0] k, input logic [7:0] f,
                                          input logic [1:0] b, input logic [7:0] p);
        logic [7:0] a; logic s; logic [2:0] bi; logic bm; logic e;
        a = 8'h00; s = 1'b0; bi = 3'd0; bm = 1'b0; e = 1'b0;
        case (k)
            2'b00: a = 8'(int'(b) * 8 + int'(f[2:0]));
            2'b01: begin a = f; s = (f >= 8'h80); end
            2'b10: if (f[2:0] <= 3'd1) a = p; else e = 1'b1;
            default: begin
                bm = 1'b1; bi = f[2:0];
                if (f < 8'h80) a = 8'h20 + (f >> 3);
                else begin a = f & 8'hF8; s = 1'b1; end
            end
        endcase
        return {a, s, bi, bm, e};
    endfunction

    task automatic check(input string tag, input logic [13:0] got, input logic [13:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got addr=%h sfr=%b bidx=%0d bmode=%b err=%b expected addr=%h sfr=%b bidx=%0d bmode=%b err=%b",
                     tag, got[13:6], got[5], got[4:2], got[1], got[0],
                     exp[13:6], exp[5], exp[4:2], exp[1], exp[0]);
        end
    endtask

    task automatic drive(input string tag, input logic [1:0] k, input logic [7:0] f,
                         input logic [1:0] b, input logic [7:0] p);
        @(negedge clk);
        kind_i = k; field_i = f; bank_i = b; ptr_i = p;
        exp_q.push_back(model(k, f, b, p));
        tag_q.push_back(tag);
    endtask

    // monitor: one result per clock, one cycle after the inputs were applied
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n && exp_q.size() > 0) begin
                check(tag_q.pop_front(), {addr_o, sfr_o, bidx_o, bmode_o, err_o},
                      exp_q.pop_front());
            end
        end
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        kind_i = 2'b01; field_i = 8'hA5;
        repeat (3) @(negedge clk);
        // R9: outputs held at zero under reset
        check("R9 reset", {addr_o, sfr_o, bidx_o, bmode_o, err_o}, 14'h0);
        rst_n = 1'b1;
        // R1 every bank with every register number
        for (int b = 0; b < 4; b++)
            for (int i = 0; i < 8; i++)
                drive("R1 register map", 2'b00, 8'(i), 2'(b), 8'hEE);
        // R2 upper field bits ignored
        for (int b = 0; b < 4; b++)
            drive("R2 upper field ignored", 2'b00, 8'hF8 | 8'(b + 3), 2'(b), 8'h11);
        // R3 every direct address
        for (int a = 0; a < 256; a++)
            drive("R3 direct", 2'b01, 8'(a), 2'(a), 8'h00);
        // R4 pointer access across the upper window, both pointer registers
        for (int a = 128; a < 256; a++)
            drive("R4 pointer upper", 2'b10, 8'(a & 1) | 8'hF0, 2'(a), 8'(a));
        drive("R4 pointer low", 2'b10, 8'h00, 2'b11, 8'h05);
        // R5 illegal pointer registers
        for (int r = 2; r < 8; r++)
            drive("R5 bad pointer", 2'b10, 8'(r), 2'b01, 8'h90);
        // R6 / R7 every bit address
        for (int a = 0; a < 256; a++)
            drive(a < 128 ? "R6 bit ram" : "R7 bit sfr", 2'b11, 8'(a), 2'(a), 8'h33);
        // R8 back to a non-bit kind after bit access
        drive("R8 flags cleared", 2'b01, 8'hD7, 2'b00, 8'h00);
        drive("R8 flags cleared", 2'b00, 8'h07, 2'b10, 8'h00);
        // R9 latency: mid-stream reset clears
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R9 async reset", {addr_o, sfr_o, bidx_o, bmode_o, err_o}, 14'h0);
        @(negedge clk);
        rst_n = 1'b1;
        drive("R9 after reset", 2'b11, 8'hE3, 2'b00, 8'h00);
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule